// File: doc/BRIEF.md
# Pin Pattern-Match Engine

This block watches a small set of input pins and evaluates a programmable sum-of-products over them. It is built from eight slices. Each slice picks one pin and one of eight conditions: constant true, constant false, high level, low level, a sticky edge (rising, falling or either), or a single-cycle either-edge event. Adjacent slices are ANDed into product terms. Endpoint flags close a term, and the engine drives one match output for each closed term that is true. A combined output ORs all of the match outputs.

Software loads two words through a plain write port. The configuration word holds the endpoint flags and the condition fields. The source word holds the pin index for each slice. Sticky edge history is wiped whenever either word is written, and whenever the engine is disabled. Every pin passes through a synchroniser before any edge or level is evaluated, so the match outputs are registered and follow the pins with a fixed latency.

Top module: `pin_pattern_engine`

## Requirements
- R1: Out of reset the configuration word is all zeros. Every slice is therefore constant true, and only slice 7 is an endpoint. With either enable input high, the next clock gives match_o = 8'h80 and match_any_o = 1.
- R2: The condition for slice n sits in configuration bits [10+3n:8+3n]. Configuration bits 0 to 6 are the endpoint flags of slices 0 to 6. Source bits [3n+2:3n] pick the pin for slice n.
- R3: Condition codes: 0 is constant true, 6 is constant false, 4 is true while the pin is high and 5 is true while it is low. A change on a pin driven between clock edges reaches match_o on the third rising edge after it, not earlier.
- R4: Code 1 latches true on a rising edge, code 2 on a falling edge and code 3 on either edge. A latched slice stays true while the pin keeps changing.
- R5: A write to either word clears all sticky history on the edge that loads the word. An edge being detected on that same edge is discarded. The new configuration governs match_o from the following edge.
- R6: With both enable inputs low, match_o and match_any_o are driven low and all sticky history is erased. Either enable input alone enables the engine.
- R7: Code 7 makes a slice true for exactly one cycle per rising or falling edge on its pin.
- R8: A product term is the AND of the slices from the one after the previous endpoint (or from slice 0) up to and including the endpoint slice. Slice 7 is always an endpoint.
- R9: The match output of a slice that is not an endpoint is always low.
- R10: match_any_o is high exactly when some bit of match_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 8 | Asynchronous pins under observation |
| en_match_i | input | 1 | Enable control A |
| en_event_i | input | 1 | Enable control B |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 32 | Configuration word: endpoints in [7:0], conditions from bit 8 up |
| src_we_i | input | 1 | Write strobe for the source word |
| src_wdata_i | input | 24 | Source word: 3-bit pin index per slice |
| match_o | output | 8 | Per-endpoint product-term match |
| match_any_o | output | 1 | OR of all match outputs |

## Verification
The level patterns drive a high-level and a low-level slice on separate pins, each as a one-slice term. They show that the correct field and pin are decoded, and a check one cycle early pins down the latency. The sticky patterns raise and then lower each pin. Outputs that remain set after the second edge separate latched history from level sensing, and a following write shows the history being wiped. In the event pattern a single toggle must give a one-cycle pulse and nothing after it. The grouping pattern breaks one slice of each of two terms, which shows that the terms are ANDed inside and kept apart from each other. An edge timed to arrive on the write edge, and a disable/re-enable cycle, check the clear rules.

// File: rtl/pe_pkg.sv
package pe_pkg;
   typedef enum logic [2:0] {
      COND_ONE      = 3'd0,
      COND_RISE_STK = 3'd1,
      COND_FALL_STK = 3'd2,
      COND_ANY_STK  = 3'd3,
      COND_HIGH     = 3'd4,
      COND_LOW      = 3'd5,
      COND_ZERO     = 3'd6,
      COND_EVENT    = 3'd7
   } cond_e;

   localparam int COND_W = 3;
endpackage

// File: rtl/pe_pin_sync.sv
// Synchroniser chain per pin plus edge extraction against the previous synchronised value.
module pe_pin_sync #(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pins_i,
   output logic [NUM_PINS-1:0] level_o,
   output logic [NUM_PINS-1:0] rise_o,
   output logic [NUM_PINS-1:0] fall_o
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pe_pin_sync: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= pins_i;
         for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
         prev_q <= stage_q[SYNC_STAGES-1];
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_edge
      assign level_o[p] = stage_q[SYNC_STAGES-1][p];
      assign rise_o[p]  = stage_q[SYNC_STAGES-1][p] & ~prev_q[p];
      assign fall_o[p]  = ~stage_q[SYNC_STAGES-1][p] & prev_q[p];
   end
endmodule

// File: rtl/pe_slice.sv
// One slice: pin selection, sticky history and condition evaluation.
module pe_slice
   import pe_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int SEL_W    = $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   input  cond_e               cond_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic [NUM_PINS-1:0] level_i,
   input  logic [NUM_PINS-1:0] rise_i,
   input  logic [NUM_PINS-1:0] fall_i,
   output logic                hit_o,
   output logic                sticky_o
);
   logic lvl, rise_m, fall_m, stk_set, sticky_q;

   assign lvl    = level_i[sel_i];
   assign rise_m = rise_i[sel_i] & ~clear_i;
   assign fall_m = fall_i[sel_i] & ~clear_i;

   always_comb begin
      case (cond_i)
         COND_RISE_STK: stk_set = rise_m;
         COND_FALL_STK: stk_set = fall_m;
         COND_ANY_STK:  stk_set = rise_m | fall_m;
         default:       stk_set = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sticky_q <= 1'b0;
      else if (clear_i) sticky_q <= 1'b0;
      else if (stk_set) sticky_q <= 1'b1;
   end

   always_comb begin
      case (cond_i)
         COND_ONE:      hit_o = 1'b1;
         COND_RISE_STK,
         COND_FALL_STK,
         COND_ANY_STK:  hit_o = sticky_q | stk_set;
         COND_HIGH:     hit_o = lvl;
         COND_LOW:      hit_o = ~lvl;
         COND_ZERO:     hit_o = 1'b0;
         COND_EVENT:    hit_o = rise_m | fall_m;
         default:       hit_o = 1'b0;
      endcase
   end

   assign sticky_o = sticky_q;
endmodule

// File: rtl/pe_term_chain.sv
// Groups slice hits into product terms closed by endpoint flags.
module pe_term_chain #(
   parameter int NUM_SLICES = 8
) (
   input  logic [NUM_SLICES-1:0] hit_i,
   input  logic [NUM_SLICES-1:0] endpt_i,
   output logic [NUM_SLICES-1:0] match_o
);
   logic [NUM_SLICES-1:0] run;

   for (genvar n = 0; n < NUM_SLICES; n++) begin : g_chain
      if (n == 0) begin : g_first
         assign run[n] = hit_i[n];
      end else begin : g_next
         assign run[n] = hit_i[n] & (endpt_i[n-1] | run[n-1]);
      end
      assign match_o[n] = endpt_i[n] & run[n];
   end
endmodule

// File: rtl/pin_pattern_engine.sv
module pin_pattern_engine
   import pe_pkg::*;
#(
   parameter int NUM_SLICES  = 8,
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(NUM_PINS),
   localparam int CFG_W      = NUM_SLICES + COND_W * NUM_SLICES,
   localparam int SRC_W      = SEL_W * NUM_SLICES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pins_i,
   input  logic                  en_match_i,
   input  logic                  en_event_i,
   input  logic                  cfg_we_i,
   input  logic [CFG_W-1:0]      cfg_wdata_i,
   input  logic                  src_we_i,
   input  logic [SRC_W-1:0]      src_wdata_i,
   output logic [NUM_SLICES-1:0] match_o,
   output logic                  match_any_o
);
   if (NUM_SLICES < 2) begin : g_bad_slices
      $error("pin_pattern_engine: NUM_SLICES must be at least 2");
   end
   if (NUM_PINS < 2 || (1 << SEL_W) != NUM_PINS) begin : g_bad_pins
      $error("pin_pattern_engine: NUM_PINS must be a power of two of at least 2");
   end

   logic [CFG_W-1:0]      cfg_q;
   logic [SRC_W-1:0]      src_q;
   logic                  enabled, clear;
   logic [NUM_PINS-1:0]   level, rise, fall;
   logic [NUM_SLICES-1:0] hit, sticky_vec, endpt, term;
   logic [NUM_SLICES-1:0] match_q;
   logic                  any_q;

   assign enabled = en_match_i | en_event_i;
   assign clear   = cfg_we_i | src_we_i | ~enabled;
   // last slice always closes a term; lower flags come from the word
   assign endpt   = {1'b1, cfg_q[NUM_SLICES-2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         src_q <= '0;
      end else begin
         if (cfg_we_i) cfg_q <= cfg_wdata_i;
         if (src_we_i) src_q <= src_wdata_i;
      end
   end

   pe_pin_sync #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins_i  (pins_i),
      .level_o (level),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   for (genvar n = 0; n < NUM_SLICES; n++) begin : g_slice
      cond_e cond_n;
      assign cond_n = cond_e'(cfg_q[NUM_SLICES + COND_W*n +: COND_W]);

      pe_slice #(
         .NUM_PINS (NUM_PINS),
         .SEL_W    (SEL_W)
      ) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear_i  (clear),
         .cond_i   (cond_n),
         .sel_i    (src_q[SEL_W*n +: SEL_W]),
         .level_i  (level),
         .rise_i   (rise),
         .fall_i   (fall),
         .hit_o    (hit[n]),
         .sticky_o (sticky_vec[n])
      );
   end

   pe_term_chain #(
      .NUM_SLICES (NUM_SLICES)
   ) u_terms (
      .hit_i   (hit),
      .endpt_i (endpt),
      .match_o (term)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= '0;
         any_q   <= 1'b0;
      end else begin
         match_q <= enabled ? term : '0;
         any_q   <= enabled & (|term);
      end
   end

   assign match_o     = match_q;
   assign match_any_o = any_q;
endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
   parameter int NUM_SLICES = 8,
   parameter int CFG_W      = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  enabled,
   input logic                  clear,
   input logic [CFG_W-1:0]      cfg_q,
   input logic [NUM_SLICES-1:0] sticky_vec,
   input logic [NUM_SLICES-1:0] match_o,
   input logic                  match_any_o
);
   p_any_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
      match_any_o == (|match_o));

   p_disable_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |=> (match_o == '0) && !match_any_o);

   p_clear_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (sticky_vec == '0));

   for (genvar n = 0; n < NUM_SLICES; n++) begin : g_bit
      // R4: history only drops after a clear
      p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(sticky_vec[n]) |-> $past(clear));
      if (n < NUM_SLICES - 1) begin : g_nonend
         p_nonend_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_q[n] |=> !match_o[n]);
      end
   end
endmodule

bind pin_pattern_engine pe_checker #(
   .NUM_SLICES (NUM_SLICES),
   .CFG_W      (CFG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enabled     (enabled),
   .clear       (clear),
   .cfg_q       (cfg_q),
   .sticky_vec  (sticky_vec),
   .match_o     (match_o),
   .match_any_o (match_any_o)
);

// File: tb/tb_pin_pattern_engine.sv
`timescale 1ns/1ps
module tb_pin_pattern_engine;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pins = '0;
   logic        en_a = 1'b0, en_b = 1'b0;
   logic        cfg_we = 1'b0, src_we = 1'b0;
   logic [31:0] cfg_d = '0;
   logic [23:0] src_d = '0;
   logic [7:0]  match;
   logic        any;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   pin_pattern_engine dut (
      .clk(clk), .rst_n(rst_n), .pins_i(pins),
      .en_match_i(en_a), .en_event_i(en_b),
      .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_d),
      .src_we_i(src_we), .src_wdata_i(src_d),
      .match_o(match), .match_any_o(any));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic chk_match(input string req, input logic [7:0] exp);
      check(req, {any, match}, {|exp, exp});
   endtask

   task automatic write_cfg(input logic [31:0] d);
      cfg_d = d; cfg_we = 1'b1; step(1); cfg_we = 1'b0;
   endtask

   task automatic write_src(input logic [23:0] d);
      src_d = d; src_we = 1'b1; step(1); src_we = 1'b0;
   endtask

   task automatic t_reset;
      step(2);
      chk_match("R1 disabled after reset", 8'h00);
      en_a = 1'b1; step(1);
      chk_match("R1 default config", 8'h80);
   endtask

   task automatic t_level;
      pins = 8'h00; step(3);
      // conds {c7..c0}: c0 high, c1 low, rest false; ends at 0 and 1
      write_cfg({3'd6,3'd6,3'd6,3'd6,3'd6,3'd6,3'd5,3'd4, 8'h03});
      write_src({18'd0, 3'd5, 3'd3});
      step(2);
      chk_match("R2 low slice on pin5", 8'h02);
      pins[3] = 1'b1; step(2);
      chk_match("R3 not before third edge", 8'h02);
      step(1);
      chk_match("R3 high slice on pin3", 8'h03);
      pins[5] = 1'b1; step(3);
      chk_match("R3 low slice drops", 8'h01);
   endtask

   task automatic t_sticky;
      pins = 8'b0000_0010; step(3);
      write_cfg({3'd6,3'd6,3'd6,3'd6,3'd6,3'd3,3'd2,3'd1, 8'h07});
      write_src({15'd0, 3'd2, 3'd1, 3'd0});
      step(2);
      chk_match("R4 no history after write", 8'h00);
      pins[0] = 1'b1; step(3);
      chk_match("R4 rising latched", 8'h01);
      pins[0] = 1'b0; step(3);
      chk_match("R4 rising held after fall", 8'h01);
      pins[1] = 1'b0; step(3);
      chk_match("R4 falling latched", 8'h03);
      pins[2] = 1'b1; step(3);
      chk_match("R4 either edge latched", 8'h07);
      pins[2] = 1'b0; step(3);
      chk_match("R4 either edge held", 8'h07);
      write_src({15'd0, 3'd2, 3'd1, 3'd0});
      step(1);
      chk_match("R5 source write clears history", 8'h00);
   endtask

   task automatic t_discard;
      pins = 8'h00; step(3);
      write_cfg({3'd1, 21'd0, 8'h00});
      write_src({3'd3, 21'd0});
      step(2);
      chk_match("R5 clean start", 8'h00);
      pins[3] = 1'b1; step(2);
      write_cfg({3'd1, 21'd0, 8'h00});
      step(3);
      chk_match("R5 edge on write edge discarded", 8'h00);
      pins[3] = 1'b0; step(3);
      pins[3] = 1'b1; step(3);
      chk_match("R5 later edge latched", 8'h80);
   endtask

   task automatic t_disable;
      en_a = 1'b0; en_b = 1'b0; step(1);
      chk_match("R6 outputs low when disabled", 8'h00);
      en_b = 1'b1; step(2);
      chk_match("R6 history erased", 8'h00);
      pins[3] = 1'b0; step(3);
      pins[3] = 1'b1; step(3);
      chk_match("R6 second enable alone works", 8'h80);
   endtask

   task automatic t_event;
      pins = 8'h00; step(3);
      write_cfg({3'd7, 21'd0, 8'h00});
      write_src({3'd4, 21'd0});
      step(2);
      chk_match("R7 idle", 8'h00);
      pins[4] = 1'b1; step(3);
      chk_match("R7 pulse on rise", 8'h80);
      step(1);
      chk_match("R7 pulse one cycle", 8'h00);
      pins[4] = 1'b0; step(3);
      chk_match("R7 pulse on fall", 8'h80);
      step(1);
      chk_match("R7 fall pulse ends", 8'h00);
   endtask

   task automatic t_product;
      pins = 8'b0100_0111; step(3);
      write_cfg({3'd4,3'd4,3'd5,3'd4,3'd4,3'd4,3'd4,3'd4, 8'h04});
      write_src({3'd6,3'd6,3'd7,3'd6,3'd6,3'd2,3'd1,3'd0});
      step(2);
      chk_match("R8 two terms true", 8'h84);
      pins[1] = 1'b0; step(3);
      chk_match("R8 first term broken only", 8'h80);
      pins[7] = 1'b1; step(3);
      chk_match("R10 no term true", 8'h00);
      pins[1] = 1'b1; step(3);
      chk_match("R9 non-endpoints low", 8'h04);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_level();
      t_sticky();
      t_discard();
      t_disable();
      t_event();
      t_product();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule